// File: doc/BRIEF.md
# Lowest-Priority Interrupt Distributor

This block steers one interrupt request at a time to exactly one of up to eight CPUs. A request arrives as a 64-bit routing entry with a valid/ready handshake. The block decodes the vector, the delivery mode, the destination mode and the destination. It compares the destination with each CPU's physical ID or logical ID and forms the set of CPUs that are eligible. It then drives a one-hot grant together with the vector.

In fixed delivery the request goes to one matching CPU without regard to priority. In lowest-priority delivery the block ranks the eligible CPUs. A CPU's rank comes from its task priority class and from the class of the vector it is currently servicing. The block excludes every CPU whose rank would block the vector. The CPU with the lowest rank wins, and when several CPUs share that rank they take turns. A request that no CPU can take stays pending. A request that names an unsupported delivery mode is discarded and flagged.

Top module: `lp_irq_router`

## Requirements
- R1: The routing entry is decoded as follows. Bits 7:0 are the vector, which is driven on `grant_vec` whenever a grant is given. Bits 10:8 are the delivery mode: 000 is fixed and 001 is lowest priority. Bit 11 is the destination mode: 1 is logical and 0 is physical. Bits 63:56 are the 8-bit destination.
- R2: In flat logical mode (`cluster_mode`=0), a CPU matches when bits 7:0 of its logical ID AND the 8-bit destination is nonzero. One destination bit may name a group of several CPUs.
- R3: In physical mode, only the CPU whose 8-bit physical ID equals the destination matches.
- R4: In cluster logical mode (`cluster_mode`=1), entry bits 63:32 form a 32-bit destination. A CPU matches when bits 31:16 of its logical ID equal destination bits 31:16, and bits 15:0 of its logical ID AND destination bits 15:0 is nonzero.
- R5: In lowest-priority delivery, exactly one eligible CPU is granted. The winner is the CPU with the lowest effective class. The effective class is the larger of task priority bits 7:4 and the in-service vector bits 7:4; the in-service class counts only while the CPU's in-service flag is set. Task priority bits 3:0 are ignored.
- R6: In lowest-priority delivery, a CPU with its in-service flag set ranks above an idle CPU of the same effective class.
- R7: In lowest-priority delivery, a CPU is a candidate only if vector bits 7:4 are strictly greater than its effective class. If no candidate exists, no grant is given and `req_ready` stays low, so the request remains pending.
- R8: When several candidates tie at the lowest rank, the search starts at the CPU after the last accepted one. Successive requests therefore rotate among the tied CPUs. After reset the search starts at CPU 0.
- R9: A CPU whose enable bit is clear never matches, in any mode.
- R10: `req_ready` rises only in a cycle where the granted CPU raises its accept bit. The rotation pointer moves only on such an acceptance.
- R11: A delivery mode other than 000 or 001 raises `req_err` and `req_ready` for that cycle and gives no grant.
- R12: In fixed delivery, the lowest-numbered enabled matching CPU is granted, whatever its priority.
- R13: `grant` is one-hot or zero, and it is zero while `req_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cluster_mode | input | 1 | Selects 32-bit cluster logical matching |
| req_valid | input | 1 | Request present |
| req_entry | input | 64 | Routing entry of the request |
| req_ready | output | 1 | Request consumed (accepted or dropped) |
| req_err | output | 1 | Unsupported delivery mode, request dropped |
| cpu_en | input | NCPU | Per-CPU enable |
| cpu_phys_id | input | 8*NCPU | Per-CPU physical ID |
| cpu_log_id | input | 32*NCPU | Per-CPU logical ID |
| cpu_tpr | input | 8*NCPU | Per-CPU task priority |
| cpu_isr_vec | input | 8*NCPU | Per-CPU highest in-service vector |
| cpu_isr_act | input | NCPU | Per-CPU in-service flag |
| cpu_accept | input | NCPU | Per-CPU accept of the grant |
| grant | output | NCPU | One-hot target CPU |
| grant_vec | output | 8 | Vector delivered with the grant |

## Verification
The assertions assume that a CPU raises its accept bit only while it sees its own grant. They also assume that the CPU state inputs settle before the clock edge at which the block samples them. The bench changes per-CPU state and the request entry only at the falling edge. It raises the accept bits only after it has observed the grant. It withdraws a pending request in the cycle after it has checked it, so a request never remains outstanding while the state that blocks it is unstable.

// File: rtl/lp_irq_router.sv
module lp_irq_router #(
  parameter int NCPU = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cluster_mode,
  input  logic                 req_valid,
  input  logic [63:0]          req_entry,
  output logic                 req_ready,
  output logic                 req_err,
  input  logic [NCPU-1:0]      cpu_en,
  input  logic [8*NCPU-1:0]    cpu_phys_id,
  input  logic [32*NCPU-1:0]   cpu_log_id,
  input  logic [8*NCPU-1:0]    cpu_tpr,
  input  logic [8*NCPU-1:0]    cpu_isr_vec,
  input  logic [NCPU-1:0]      cpu_isr_act,
  input  logic [NCPU-1:0]      cpu_accept,
  output logic [NCPU-1:0]      grant,
  output logic [7:0]           grant_vec
);
  localparam int PW = (NCPU > 1) ? $clog2(NCPU) : 1;

  logic [7:0]  vec;
  logic [2:0]  dmode;
  logic        lmode;
  logic [7:0]  dflat;
  logic [31:0] dclu;
  logic        is_fixed, is_lp, bad;

  assign vec      = req_entry[7:0];
  assign dmode    = req_entry[10:8];
  assign lmode    = req_entry[11];
  assign dflat    = req_entry[63:56];
  assign dclu     = req_entry[63:32];
  assign is_fixed = (dmode == 3'b000);
  assign is_lp    = (dmode == 3'b001);
  assign bad      = req_valid && !is_fixed && !is_lp;

  logic [NCPU-1:0] elig, cand, tie, fix_pick, rr_pick, sel;
  logic [4:0]      key [NCPU];
  logic [4:0]      kmin;
  logic [PW-1:0]   ptr, win;

  always_comb begin
    for (int i = 0; i < NCPU; i++) begin
      logic [31:0] lid;
      logic [3:0]  tcls, icls, ecls;
      logic        hit;
      lid  = cpu_log_id[i*32 +: 32];
      tcls = cpu_tpr[i*8+4 +: 4];
      icls = cpu_isr_act[i] ? cpu_isr_vec[i*8+4 +: 4] : 4'h0;
      ecls = (tcls > icls) ? tcls : icls;
      if (!lmode)
        hit = (cpu_phys_id[i*8 +: 8] == dflat);
      else if (cluster_mode)
        hit = (lid[31:16] == dclu[31:16]) && |(lid[15:0] & dclu[15:0]);
      else
        hit = |(lid[7:0] & dflat);
      elig[i] = hit && cpu_en[i];
      key[i]  = {ecls, cpu_isr_act[i]};
      cand[i] = elig[i] && (vec[7:4] > ecls);
    end
  end

  always_comb begin
    kmin = 5'h1F;
    for (int i = 0; i < NCPU; i++)
      if (cand[i] && key[i] < kmin) kmin = key[i];
    for (int i = 0; i < NCPU; i++)
      tie[i] = cand[i] && (key[i] == kmin);
  end

  always_comb begin
    logic found;
    rr_pick = '0;
    found   = 1'b0;
    for (int k = 0; k < NCPU; k++) begin
      int j;
      j = int'(ptr) + k;
      if (j >= NCPU) j = j - NCPU;
      if (!found && tie[j]) begin
        rr_pick[j] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  always_comb begin
    fix_pick = '0;
    for (int i = NCPU - 1; i >= 0; i--)
      if (elig[i]) fix_pick = NCPU'(1) << i;
  end

  assign sel       = is_fixed ? fix_pick : (is_lp ? rr_pick : '0);
  assign grant     = req_valid ? sel : '0;
  assign grant_vec = vec;
  assign req_err   = bad;
  assign req_ready = bad || |(grant & cpu_accept);

  always_comb begin
    win = '0;
    for (int i = 0; i < NCPU; i++)
      if (grant[i]) win = PW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr <= '0;
    else if (|(grant & cpu_accept))
      ptr <= (win == PW'(NCPU - 1)) ? '0 : win + PW'(1);
  end

  logic unused_bits;
  always_comb begin
    unused_bits = ^req_entry[31:12];
    for (int i = 0; i < NCPU; i++)
      unused_bits = unused_bits ^ (^cpu_tpr[i*8 +: 4]) ^ (^cpu_isr_vec[i*8 +: 4]);
  end
endmodule

module lp_irq_router_chk #(
  parameter int NCPU = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [63:0]        req_entry,
  input logic               req_ready,
  input logic               req_err,
  input logic [NCPU-1:0]    cpu_en,
  input logic [8*NCPU-1:0]  cpu_tpr,
  input logic [NCPU-1:0]    cpu_accept,
  input logic [NCPU-1:0]    grant
);
  logic blocked;
  always_comb begin
    blocked = 1'b0;
    for (int i = 0; i < NCPU; i++)
      if (grant[i] && req_entry[10:8] == 3'b001 && req_entry[7:4] <= cpu_tpr[i*8+4 +: 4])
        blocked = 1'b1;
  end

  // R13
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R13
  grant_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> grant == '0);
  // R9
  grant_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~cpu_en) == '0);
  // R11
  err_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (req_ready && grant == '0));
  // R10
  ready_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_err) |-> |(grant & cpu_accept));
  // R7
  tpr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blocked);
endmodule

bind lp_irq_router lp_irq_router_chk #(.NCPU(NCPU)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_entry(req_entry),
  .req_ready(req_ready), .req_err(req_err), .cpu_en(cpu_en), .cpu_tpr(cpu_tpr),
  .cpu_accept(cpu_accept), .grant(grant)
);

// File: tb/lp_irq_router_test.sv
module lp_irq_router_test;
  localparam int N = 8;

  logic clk = 0, rst_n = 0, cluster_mode = 0, req_valid = 0;
  logic [63:0] req_entry = '0;
  logic req_ready, req_err;
  logic [N-1:0] cpu_en = '0, cpu_isr_act = '0, cpu_accept = '0, grant;
  logic [8*N-1:0] cpu_phys_id, cpu_tpr, cpu_isr_vec;
  logic [32*N-1:0] cpu_log_id;
  logic [7:0] grant_vec;

  logic [7:0]  pid [N];
  logic [31:0] lid [N];
  logic [7:0]  tpr [N];
  logic [7:0]  isv [N];

  for (genvar i = 0; i < N; i++) begin : g_drv
    assign cpu_phys_id[i*8 +: 8] = pid[i];
    assign cpu_log_id[i*32 +: 32] = lid[i];
    assign cpu_tpr[i*8 +: 8] = tpr[i];
    assign cpu_isr_vec[i*8 +: 8] = isv[i];
  end

  lp_irq_router #(.NCPU(N)) uut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, ptr_m = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] model(input logic [63:0] e);
    logic [N-1:0] r = '0;
    logic [2:0] dm = e[10:8];
    int best = -1, bkey = 0;
    if (dm > 3'd1) return '0;
    for (int k = 0; k < N; k++) begin
      int i = (ptr_m + k) % N;
      bit m;
      int ecls, key;
      if (!e[11]) m = (pid[i] == e[63:56]);
      else if (cluster_mode) m = (lid[i][31:16] == e[63:48]) && ((lid[i][15:0] & e[47:32]) != 0);
      else m = ((lid[i][7:0] & e[63:56]) != 0);
      m = m && cpu_en[i];
      ecls = int'(tpr[i][7:4]);
      if (cpu_isr_act[i] && int'(isv[i][7:4]) > ecls) ecls = int'(isv[i][7:4]);
      key = ecls * 2 + int'(cpu_isr_act[i]);
      if (dm == 3'd0) begin
        if (m && (best < 0 || i < best)) best = i;
      end else if (m && int'(e[7:4]) > ecls && (best < 0 || key < bkey)) begin
        best = i; bkey = key;
      end
    end
    if (best >= 0) r[best] = 1'b1;
    return r;
  endfunction

  task automatic run(input logic [63:0] e, input bit acc, input string tag, output logic [N-1:0] g);
    logic [N-1:0] exp;
    bit experr;
    @(negedge clk);
    req_entry = e; req_valid = 1; cpu_accept = acc ? '1 : '0;
    #1;
    exp = model(e);
    experr = (e[10:8] > 3'd1);
    chk(grant == exp, {tag, " grant"}, 64'(grant), 64'(exp));
    chk(req_err == experr, {tag, " R11 err"}, 64'(req_err), 64'(experr));
    chk(req_ready == (experr || (acc && exp != 0)), {tag, " R10 ready"}, 64'(req_ready), 64'(experr || (acc && exp != 0)));
    if (exp != 0) chk(grant_vec == e[7:0], {tag, " R1 vector"}, 64'(grant_vec), 64'(e[7:0]));
    g = grant;
    @(posedge clk);
    if (acc && exp != 0)
      for (int i = 0; i < N; i++) if (exp[i]) ptr_m = (i + 1) % N;
    #1 req_valid = 0; cpu_accept = '0;
  endtask

  function automatic logic [63:0] ent(input logic [7:0] dst, input bit logi, input logic [2:0] dm, input logic [7:0] v);
    return {dst, 44'd0, logi, dm, v};
  endfunction

  task automatic idle_all();
    for (int i = 0; i < N; i++) begin
      pid[i] = 8'(i); lid[i] = 32'd0; tpr[i] = 8'h00; isv[i] = 8'h00;
    end
    cpu_isr_act = '0; cpu_en = '1; cluster_mode = 0;
  endtask

  initial begin
    logic [N-1:0] g;
    idle_all();
    repeat (3) @(posedge clk);
    #1;
    chk(grant == 0 && req_ready == 0 && req_err == 0, "R13 reset outputs", {grant, req_ready, req_err}, 0);
    rst_n = 1;

    // R8 rotation across four tied CPUs
    idle_all(); cpu_en = 8'h0F;
    for (int i = 0; i < 4; i++) lid[i] = 32'h1;
    for (int k = 0; k < 4; k++) begin
      run(ent(8'h01, 1, 3'b001, 8'h30), 1, "R8 tie", g);
      chk(g == N'(1 << k), "R8 rotation", 64'(g), 64'(1 << k));
    end
    // R10 withheld accept keeps the pointer
    run(ent(8'h01, 1, 3'b001, 8'h30), 0, "R10 hold", g);
    chk(g == 8'h01, "R10 hold target", 64'(g), 64'h01);
    run(ent(8'h01, 1, 3'b001, 8'h30), 1, "R10 retry", g);
    chk(g == 8'h01, "R10 same target", 64'(g), 64'h01);
    // R7 block at class 2, then release; R5 low nibble ignored
    idle_all(); cpu_en = 8'h01; lid[0] = 32'h1; tpr[0] = 8'h20;
    run(ent(8'h01, 1, 3'b001, 8'h25), 1, "R7 blocked", g);
    chk(g == 0, "R7 pending", 64'(g), 0);
    tpr[0] = 8'h1F;
    run(ent(8'h01, 1, 3'b001, 8'h25), 1, "R5 low nibble", g);
    chk(g == 8'h01, "R5 low nibble ignored", 64'(g), 64'h01);
    // R6 servicing CPU loses to an idle one of equal class
    idle_all(); cpu_en = 8'h03; lid[0] = 32'h1; lid[1] = 32'h1;
    tpr[0] = 8'h10; isv[0] = 8'h12; cpu_isr_act = 8'h01; tpr[1] = 8'h10;
    run(ent(8'h01, 1, 3'b001, 8'h40), 1, "R6 busy", g);
    chk(g == 8'h02, "R6 idle preferred", 64'(g), 64'h02);
    // R5 in-service class raises rank
    isv[0] = 8'h31; tpr[1] = 8'h20; cpu_isr_act = 8'h01;
    run(ent(8'h01, 1, 3'b001, 8'h40), 1, "R5 isr class", g);
    chk(g == 8'h02, "R5 lower class wins", 64'(g), 64'h02);
    // R3 physical fixed; R12 fixed logical lowest index
    idle_all(); tpr[5] = 8'hF0;
    run(ent(8'h05, 0, 3'b000, 8'h21), 1, "R3 physical", g);
    chk(g == 8'h20, "R3 physical target", 64'(g), 64'h20);
    lid[2] = 32'h4; lid[6] = 32'h4; tpr[2] = 8'hF0;
    run(ent(8'h04, 1, 3'b000, 8'h21), 1, "R12 fixed", g);
    chk(g == 8'h04, "R12 lowest index", 64'(g), 64'h04);
    // R9 disabled CPU excluded
    cpu_en[2] = 0;
    run(ent(8'h04, 1, 3'b000, 8'h21), 1, "R9 disabled", g);
    chk(g == 8'h40, "R9 next enabled", 64'(g), 64'h40);
    // R2 group bit shared
    idle_all(); lid[3] = 32'h81; lid[4] = 32'h80; tpr[3] = 8'h40;
    run(ent(8'h80, 1, 3'b001, 8'h50), 1, "R2 group", g);
    chk(g == 8'h10, "R2 group member", 64'(g), 64'h10);
    // R4 cluster mode
    idle_all(); cluster_mode = 1;
    lid[0] = 32'h0001_0001; lid[1] = 32'h0001_0002; lid[2] = 32'h0001_0004; lid[3] = 32'h0002_0001;
    run({32'h0001_0005, 20'd0, 1'b1, 3'b000, 8'h33}, 1, "R4 cluster fixed", g);
    chk(g == 8'h01, "R4 member 0", 64'(g), 64'h01);
    tpr[0] = 8'h30;
    run({32'h0001_0005, 20'd0, 1'b1, 3'b001, 8'h35}, 1, "R4 cluster lp", g);
    chk(g == 8'h04, "R4 member 2", 64'(g), 64'h04);
    // R11 unsupported mode
    idle_all(); lid[0] = 32'h1;
    run(ent(8'h01, 1, 3'b101, 8'h30), 1, "R11 bad mode", g);
    chk(g == 0, "R11 no grant", 64'(g), 0);

    // R5 R8 random mix
    void'($urandom(32'd20240611));
    for (int t = 0; t < 400; t++) begin
      logic [63:0] e;
      logic [2:0] dm;
      for (int i = 0; i < N; i++) begin
        pid[i] = 8'(i);
        lid[i] = {15'd0, 1'($urandom_range(1)), 8'd0, 8'($urandom)};
        tpr[i] = {4'($urandom_range(3)), 4'($urandom)};
        isv[i] = {4'($urandom_range(2, 5)), 4'($urandom)};
      end
      cpu_en = N'($urandom) | N'($urandom);
      cpu_isr_act = N'($urandom);
      cluster_mode = ($urandom_range(7) == 0);
      dm = ($urandom_range(15) == 0) ? 3'($urandom_range(2, 7)) : 3'($urandom_range(1));
      e = {32'($urandom), 20'd0, 1'($urandom), dm, 4'($urandom_range(2, 7)), 4'($urandom)};
      if (!e[11]) e[63:56] = 8'($urandom_range(N));
      run(e, $urandom_range(3) != 0, "R5 R8 random", g);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule